// File: doc/BRIEF.md
# Framing Data Link Byte Serializer

This block takes a byte written by a host and sends it one bit at a time into the outgoing T1 frame stream. Each bit lands in a data link slot in ESF mode, or in an Fs framing slot in D4 mode. The framer marks each such slot with a one-cycle strobe. The block then drives the serial output bit for that slot. The bit comes from the byte register when the source select is high, and from the framer's alternate internal bit when it is low.

A host write goes first into a holding register. That value is copied into the active byte only at a byte boundary, so a write in the middle of a byte cannot damage the byte on the line. When the last bit of a byte has gone out, a sticky empty flag is raised. The flag drives an active-low interrupt if the host has unmasked it. If the host does not write a new byte in time, the active byte is reloaded with the unchanged holding value and is sent again. At 250 µs per slot, the host has about 2 ms to refill the register.

Bits go out exactly as written, with no zero insertion. In D4 mode a byte is six slots long and uses only bits 5..0, which carry the Fs pattern. Loading 1Ch gives the standard D4 Fs sequence.

Top module: `fdl_serializer`

## Requirements
- R1: After reset, txBit is 0, statusEmpty is 0, irqN is 1, and both the holding register and the active byte are 00h.
- R2: In ESF mode (modeD4=0) with srcSel=1, successive slot strobes send bits 0 through 7 of the active byte, least significant bit first. txBit takes each value in the cycle after its strobe.
- R3: statusEmpty goes to 1 in the cycle after the strobe that sends the last bit of a byte with srcSel=1. That is bit 7 in ESF mode and bit 5 in D4 mode.
- R4: statusEmpty stays at 1 until a status write with hostStatIn=1. A status write with hostStatIn=0 leaves it unchanged.
- R5: If an empty event and a clearing status write happen in the same cycle, statusEmpty ends up at 1.
- R6: irqN is 0 exactly when statusEmpty=1 and the mask bit (set by a mask write, 1 meaning enabled) is 1. Otherwise irqN is 1.
- R7: If no data write arrives before a byte boundary, the next byte sent is identical to the previous one.
- R8: A data write during a byte leaves that byte's remaining bits unchanged. The new value is sent starting with the next byte, and this includes a write made in the same cycle as the boundary strobe.
- R9: In D4 mode (modeD4=1) a byte is six slots long and sends bits 0 through 5 of the active byte. A value of 1Ch gives the slot sequence 0,0,1,1,1,0.
- R10: On a strobe with srcSel=0, txBit takes the value of altBit. The bit position does not advance and no empty event is raised.
- R11: Bits are sent without zero insertion. A byte of FFh produces eight consecutive 1 bits.
- R12: In a cycle with no slot strobe, txBit, the bit position and statusEmpty (unless it is cleared) do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostDataWe | input | 1 | Write strobe for the data byte |
| hostDataIn | input | 8 | Data byte to send |
| hostStatWe | input | 1 | Write strobe for the status register |
| hostStatIn | input | 1 | Status write data; 1 clears the empty flag |
| hostMaskWe | input | 1 | Write strobe for the interrupt mask |
| hostMaskIn | input | 1 | Mask value; 1 enables the interrupt |
| statusEmpty | output | 1 | Sticky byte-empty flag |
| irqN | output | 1 | Interrupt, active low |
| slotStb | input | 1 | One-cycle strobe marking a data link or Fs bit slot |
| modeD4 | input | 1 | 1 selects D4 (six-bit bytes), 0 selects ESF (eight-bit bytes) |
| srcSel | input | 1 | 1 sends bits from this register, 0 forwards altBit |
| altBit | input | 1 | Alternate internal bit source |
| txBit | output | 1 | Serial bit output for the current slot |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 6-bit Fs field. With these values both byte lengths and both boundary positions, bit 7 and bit 5, can be reached within a few slots. This lets directed cases place a data write and a status clear exactly on the boundary strobe. A long random run then mixes mode switches in the middle of a byte, source toggles, writes, clears and mask changes. Every cycle is compared against a bench model.

// File: rtl/fdl_serializer_pkg.sv
package fdl_serializer_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic txUpd;     // a bit slot is happening this cycle
    logic useReg;    // the slot takes its bit from the register path
    logic byteLoad;  // byte boundary: reload the active byte
  } ctrl_stb_t;

endpackage

// File: rtl/fdl_serializer_ctrl.sv
module fdl_serializer_ctrl
  import fdl_serializer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FS_W   = 6,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStb,
  input  logic             srcSel,
  input  logic             modeD4,
  input  logic             hostStatWe,
  input  logic             hostStatIn,
  input  logic             hostMaskWe,
  input  logic             hostMaskIn,
  output ctrl_stb_t        ctrlStb,
  output logic [CNT_W-1:0] bitIdx,
  output logic             statusEmpty,
  output logic             irqN
);

  localparam logic [CNT_W-1:0] LAST_ESF = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_D4  = CNT_W'(FS_W - 1);

  logic [CNT_W-1:0] lastIdx;
  logic             atLast;
  logic             regSlot;
  logic             maskEn;
  logic             clearReq;

  // The boundary uses >= so that a mode change in the middle of a byte
  // cannot leave the counter stuck beyond the shorter length
  assign lastIdx  = modeD4 ? LAST_D4 : LAST_ESF;
  assign atLast   = (bitIdx >= lastIdx);
  assign regSlot  = slotStb && srcSel;
  assign clearReq = hostStatWe && hostStatIn;

  always_comb begin
    ctrlStb.txUpd    = slotStb;
    ctrlStb.useReg   = srcSel;
    ctrlStb.byteLoad = regSlot && atLast;
  end

  // Bit position counter; it only moves on slots served by the register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (regSlot) begin
      if (atLast) bitIdx <= '0;
      else        bitIdx <= bitIdx + 1'b1;
    end
  end

  // Sticky empty flag; a new empty event beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusEmpty <= 1'b0;
    end else if (ctrlStb.byteLoad) begin
      statusEmpty <= 1'b1;
    end else if (clearReq) begin
      statusEmpty <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskEn <= 1'b0;
    else if (hostMaskWe) maskEn <= hostMaskIn;
  end

  assign irqN = ~(statusEmpty & maskEn);

endmodule

// File: rtl/fdl_serializer_dp.sv
module fdl_serializer_dp
  import fdl_serializer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostDataWe,
  input  logic [BYTE_W-1:0] hostDataIn,
  input  ctrl_stb_t         ctrlStb,
  input  logic [CNT_W-1:0]  bitIdx,
  input  logic              altBit,
  output logic              txBit
);

  logic [BYTE_W-1:0] holdByte;
  logic [BYTE_W-1:0] activeByte;
  logic [BYTE_W-1:0] nextByte;
  logic [BYTE_W-1:0] bitSel;
  logic              regBit;
  logic              slotBit;

  // Host writes always land in the holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdByte <= '0;
    else if (hostDataWe) holdByte <= hostDataIn;
  end

  // A write in the boundary cycle goes straight into the next byte
  assign nextByte = hostDataWe ? hostDataIn : holdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 activeByte <= '0;
    else if (ctrlStb.byteLoad) activeByte <= nextByte;
  end

  // One-hot decode of the bit position, then an AND-OR reduction
  for (genvar g = 0; g < BYTE_W; g++) begin : g_sel
    assign bitSel[g] = (bitIdx == CNT_W'(g)) && activeByte[g];
  end
  assign regBit = |bitSel;

  assign slotBit = ctrlStb.useReg ? regBit : altBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txBit <= 1'b0;
    else if (ctrlStb.txUpd) txBit <= slotBit;
  end

endmodule

// File: rtl/fdl_serializer.sv
module fdl_serializer
  import fdl_serializer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FS_W   = 6,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostDataWe,
  input  logic [BYTE_W-1:0] hostDataIn,
  input  logic              hostStatWe,
  input  logic              hostStatIn,
  input  logic              hostMaskWe,
  input  logic              hostMaskIn,
  output logic              statusEmpty,
  output logic              irqN,
  input  logic              slotStb,
  input  logic              modeD4,
  input  logic              srcSel,
  input  logic              altBit,
  output logic              txBit
);

  ctrl_stb_t        ctrlStb;
  logic [CNT_W-1:0] bitIdx;

  fdl_serializer_ctrl #(.BYTE_W(BYTE_W), .FS_W(FS_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotStb    (slotStb),
    .srcSel     (srcSel),
    .modeD4     (modeD4),
    .hostStatWe (hostStatWe),
    .hostStatIn (hostStatIn),
    .hostMaskWe (hostMaskWe),
    .hostMaskIn (hostMaskIn),
    .ctrlStb    (ctrlStb),
    .bitIdx     (bitIdx),
    .statusEmpty(statusEmpty),
    .irqN       (irqN)
  );

  fdl_serializer_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostDataWe(hostDataWe),
    .hostDataIn(hostDataIn),
    .ctrlStb   (ctrlStb),
    .bitIdx    (bitIdx),
    .altBit    (altBit),
    .txBit     (txBit)
  );

endmodule

// File: rtl/fdl_serializer_chk.sv
module fdl_serializer_chk (
  input logic clk,
  input logic rstN,
  input logic hostStatWe,
  input logic hostStatIn,
  input logic statusEmpty,
  input logic irqN,
  input logic slotStb,
  input logic srcSel,
  input logic altBit,
  input logic txBit,
  input logic byteLoad
);

  AST_EMPTY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusEmpty && !(hostStatWe && hostStatIn) |=> statusEmpty); // R4

  AST_EMPTY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusEmpty) |-> $past(slotStb && srcSel)); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    byteLoad && hostStatWe && hostStatIn |=> statusEmpty); // R5

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> statusEmpty); // R6

  AST_ALT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    slotStb && !srcSel |=> txBit == $past(altBit)); // R10

  AST_NO_EVENT_ON_ALT: assert property (@(posedge clk) disable iff (!rstN)
    !srcSel |-> !byteLoad); // R10

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slotStb |=> $stable(txBit)); // R12

endmodule

bind fdl_serializer fdl_serializer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostStatWe (hostStatWe),
  .hostStatIn (hostStatIn),
  .statusEmpty(statusEmpty),
  .irqN       (irqN),
  .slotStb    (slotStb),
  .srcSel     (srcSel),
  .altBit     (altBit),
  .txBit      (txBit),
  .byteLoad   (ctrlStb.byteLoad)
);

// File: tb/tb_fdl_serializer.sv
module tb_fdl_serializer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostDataWe = 1'b0;
  logic [7:0] hostDataIn = '0;
  logic       hostStatWe = 1'b0;
  logic       hostStatIn = 1'b0;
  logic       hostMaskWe = 1'b0;
  logic       hostMaskIn = 1'b0;
  logic       statusEmpty;
  logic       irqN;
  logic       slotStb = 1'b0;
  logic       modeD4 = 1'b0;
  logic       srcSel = 1'b1;
  logic       altBit = 1'b0;
  logic       txBit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [7:0] mHold = '0, mCur = '0;
  int         mCnt = 0;
  logic       mStat = 1'b0, mMask = 1'b0, mTx = 1'b0;

  always #4 clk = ~clk;

  fdl_serializer dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update for one clock edge, built from the requirements
  function automatic void modelEdge();
    int  lastI;
    bit  regSlot, evt;
    lastI   = modeD4 ? 5 : 7;
    regSlot = slotStb && srcSel;
    evt     = regSlot && (mCnt >= lastI);
    if (slotStb) mTx = srcSel ? mCur[mCnt] : altBit;
    if (regSlot) mCnt = evt ? 0 : mCnt + 1;
    if (evt) mCur = hostDataWe ? hostDataIn : mHold;
    if (hostDataWe) mHold = hostDataIn;
    if (evt) mStat = 1'b1;
    else if (hostStatWe && hostStatIn) mStat = 1'b0;
    if (hostMaskWe) mMask = hostMaskIn;
  endfunction

  // Inputs are already driven at a falling edge; apply one rising edge,
  // then compare at the next falling edge
  task automatic tick(input string txTag);
    bit wasSlot;
    wasSlot = slotStb;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(wasSlot ? txTag : "R12 txBit hold", txBit, mTx);
    chk("R3 R4 R5 statusEmpty", statusEmpty, mStat);
    chk("R6 irqN", irqN, ~(mStat & mMask));
    hostDataWe = 0; hostStatWe = 0; hostMaskWe = 0; slotStb = 0;
  endtask

  task automatic slots(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      slotStb = 1'b1;
      tick(tag);
      tick(tag);
    end
  endtask

  task automatic wrData(input logic [7:0] v);
    hostDataWe = 1'b1; hostDataIn = v;
  endtask

  task automatic wrStat(input logic v);
    hostStatWe = 1'b1; hostStatIn = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pattern;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 txBit", txBit, 1'b0);
    chk("R1 statusEmpty", statusEmpty, 1'b0);
    chk("R1 irqN", irqN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    // R1: the first byte after reset is all zeros; R2 then A5h, LSB first
    hostMaskWe = 1'b1; hostMaskIn = 1'b1;
    wrData(8'hA5);
    tick("R2");
    slots(8, "R1 first byte zero");
    slots(8, "R2 A5h LSB first");
    // R4: a status write of 0 has no effect, a status write of 1 clears
    wrStat(1'b0); tick("R4");
    wrStat(1'b1); tick("R4");
    // R7: no refill, so the same byte is sent again
    slots(8, "R7 resend");
    // R8: a write in the middle of a byte waits for the boundary
    slots(3, "R8");
    wrData(8'h3C);
    slots(5, "R8 mid-byte");
    slots(8, "R8 new byte");
    // R8 and R5: data write and clear together on the boundary strobe
    slots(7, "R8");
    wrData(8'hC3); wrStat(1'b1);
    slotStb = 1'b1; tick("R5 R8 boundary");
    slots(8, "R8 boundary write");
    // R11: FFh goes out as eight 1s with nothing inserted
    wrData(8'hFF);
    slots(8, "R11");
    slots(8, "R11 all ones");
    // R9: D4 mode, 1Ch Fs pattern
    wrData(8'h1C);
    slots(8, "R9");
    modeD4 = 1'b1;
    slots(6, "R9");
    slots(12, "R9 Fs pattern");
    // R10: alternate source
    srcSel = 1'b0;
    for (int i = 0; i < 10; i++) begin
      altBit = i[0] ^ i[2];
      slotStb = 1'b1; tick("R10 alt source");
    end
    srcSel = 1'b1;
    slots(6, "R10 position frozen");
    hostMaskWe = 1'b1; hostMaskIn = 1'b0; tick("R6");

    // Random phase with a fixed seed
    void'($urandom(32'h5EED_0451));
    for (int i = 0; i < 6000; i++) begin
      slotStb    = ($urandom_range(0, 2) == 0);
      srcSel     = ($urandom_range(0, 5) != 0);
      altBit     = $urandom_range(0, 1);
      hostDataWe = ($urandom_range(0, 15) == 0);
      pattern    = 8'($urandom);
      hostDataIn = pattern;
      hostStatWe = ($urandom_range(0, 9) == 0);
      hostStatIn = $urandom_range(0, 1);
      hostMaskWe = ($urandom_range(0, 30) == 0);
      hostMaskIn = $urandom_range(0, 1);
      if ($urandom_range(0, 400) == 0) modeD4 = ~modeD4;
      tick("R2 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule